// File: doc/BRIEF.md
# Programmable PCI Interrupt Router

The router takes level-sensitive INTx lines from up to 32 device slots and merges them onto eight shared interrupt request lines, called A through H. Each line is then delivered to one of two interrupt controllers. In APIC mode, the eight lines drive a fixed group of eight I/O APIC inputs. In legacy mode, each line is steered through its own routing register to a selectable legacy PIC input.

Slots 0 to 24 have a fixed rotating assignment that spreads them over lines E to H. Each of slots 25 to 31 has a programmable map register, with one field for each INTx pin. Configuration uses a simple write-strobe and address port with a combinational read-back. Both output buses are registered.

Top module: `pci_irq_router`

## Requirements
- R1: After reset the mode is APIC (address 0 reads 1), every line-routing register reads 0x80, every slot map register reads 0x8888, and both output buses are zero.
- R2: For slots 0 to 24, pin p of slot s (INTA=0 … INTD=3, input bit 4*s+p) feeds line 4+((s+p) mod 4), where lines are numbered A=0 … H=7.
- R3: Slot s in 25..31 has a map register at address s. For pin p, the field at bits 4p+3..4p routes the pin: bits 2:0 select the line, and bit 3 set means the pin reaches no line.
- R4: Each line is the OR of all INTx levels currently routed to it. It stays high while any contributor is high.
- R5: The mode bit is bit 0 at address 0, and 1 selects APIC mode. In APIC mode, line k drives apic_irq_o[16+k], apic_irq_o[15:0] stay low, and pic_irq_o stays low.
- R6: In PIC mode (mode bit 0), the routing register for line k is at address 8+k. Bits 3:0 select the PIC input and bit 7 set disables the route. pic_irq_o[n] is the OR of every enabled line that selects n, and apic_irq_o stays all low.
- R7: Both output buses are registered. A change on the INTx inputs or in the configuration appears on the outputs at the next rising clock edge, not before.
- R8: Reads return the stored value at the addressed register. For a line-routing register only bits 7 and 3:0 are kept, and for the mode register only bit 0 is kept. Unmapped addresses read 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_i | input | 128 | INTx levels, bit 4*slot+pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration register address |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Read data for cfg_addr_i |
| pic_irq_o | output | 16 | Legacy PIC request levels |
| apic_irq_o | output | 24 | I/O APIC request levels |

## Verification
The assertions watch the mode exclusivity on every cycle: the APIC bus is quiet in PIC mode, the PIC bus is quiet in APIC mode, and the low APIC inputs are never driven. They also check that fixed slots never reach lines A to D, that an idle line set yields quiet outputs a cycle later, and that mode writes take effect. The exact mapping can only be shown by the bench's scenarios, which model it independently. These cover the rotating pattern for every slot and pin, the programmed fields including disabled ones, OR merging, several lines folded onto one PIC input, the one-cycle output latency and ignored writes to unmapped addresses.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int PIRQ_N     = 8;
    localparam int PIN_N      = 4;
    localparam int FIELD_W    = 4;
    localparam int MAP_W      = PIN_N * FIELD_W;
    localparam int ROUTE_W    = 8;
    localparam int PIC_N      = 16;
    localparam int APIC_N     = 24;
    localparam int APIC_BASE  = 16;
    localparam int ROUTE_BASE = 8;
    localparam int DIS_BIT    = 7;
    localparam logic [ROUTE_W-1:0] ROUTE_RST = 8'h80;
    localparam logic [MAP_W-1:0]   MAP_RST   = 16'h8888;
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_FIXED = 25,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    output logic [DATA_W-1:0]                  rdata_o,
    output logic                               apic_mode_o,
    output logic [PIRQ_N-1:0][ROUTE_W-1:0]     route_o,
    output logic [NUM_SLOTS-NUM_FIXED-1:0][MAP_W-1:0] map_o
);
    localparam int NPROG = NUM_SLOTS - NUM_FIXED;

    typedef struct packed {
        logic                          apic_mode;
        logic [PIRQ_N-1:0][ROUTE_W-1:0] route;
        logic [NPROG-1:0][MAP_W-1:0]   map;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        int a;
        cfg_d   = cfg_q;
        a       = int'(addr_i);
        rdata_o = '0;
        if (a == 0) begin
            rdata_o = DATA_W'(cfg_q.apic_mode);
            if (we_i) cfg_d.apic_mode = wdata_i[0];
        end else if (a >= ROUTE_BASE && a < ROUTE_BASE + PIRQ_N) begin
            rdata_o = DATA_W'(cfg_q.route[a-ROUTE_BASE]);
            if (we_i) cfg_d.route[a-ROUTE_BASE] = {wdata_i[DIS_BIT], 3'b000, wdata_i[3:0]};
        end else if (a >= NUM_FIXED && a < NUM_SLOTS) begin
            rdata_o = DATA_W'(cfg_q.map[a-NUM_FIXED]);
            if (we_i) cfg_d.map[a-NUM_FIXED] = wdata_i[MAP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.apic_mode <= 1'b1;
            cfg_q.route     <= {PIRQ_N{ROUTE_RST}};
            cfg_q.map       <= {NPROG{MAP_RST}};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign apic_mode_o = cfg_q.apic_mode;
    assign route_o     = cfg_q.route;
    assign map_o       = cfg_q.map;

    // R8
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == '0) |=> (apic_mode_o == $past(wdata_i[0])));
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
    import pirq_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_FIXED = 25
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_SLOTS*PIN_N-1:0]                intx_i,
    input  logic [NUM_SLOTS-NUM_FIXED-1:0][MAP_W-1:0] map_i,
    output logic [PIRQ_N-1:0]                         pirq_o
);
    localparam int SEL_W = $clog2(PIRQ_N);

    logic [NUM_SLOTS*PIN_N-1:0]            en;
    logic [NUM_SLOTS*PIN_N-1:0][SEL_W-1:0] sel;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < PIN_N; p++) begin : g_pin
            if (s < NUM_FIXED) begin : g_fixed
                localparam int TGT = (PIRQ_N - PIN_N) + ((s + p) % PIN_N);
                assign en[s*PIN_N+p]  = 1'b1;
                assign sel[s*PIN_N+p] = SEL_W'(TGT);
            end else begin : g_prog
                assign en[s*PIN_N+p]  = ~map_i[s-NUM_FIXED][p*FIELD_W+FIELD_W-1];
                assign sel[s*PIN_N+p] = map_i[s-NUM_FIXED][p*FIELD_W +: SEL_W];
            end
        end
    end

    always_comb begin
        pirq_o = '0;
        for (int i = 0; i < NUM_SLOTS*PIN_N; i++) begin
            if (en[i] && intx_i[i]) pirq_o[sel[i]] = 1'b1;
        end
    end

    // R2
    fixed_upper_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_i[NUM_SLOTS*PIN_N-1:NUM_FIXED*PIN_N] == '0) |-> (pirq_o[PIRQ_N-PIN_N-1:0] == '0));
endmodule

// File: rtl/pirq_deliver.sv
module pirq_deliver
    import pirq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           apic_mode_i,
    input  logic [PIRQ_N-1:0][ROUTE_W-1:0] route_i,
    input  logic [PIRQ_N-1:0]              pirq_i,
    output logic [PIC_N-1:0]               pic_irq_o,
    output logic [APIC_N-1:0]              apic_irq_o
);
    localparam int IRQ_W = $clog2(PIC_N);

    typedef struct packed {
        logic [PIC_N-1:0]  pic;
        logic [APIC_N-1:0] apic;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        for (int k = 0; k < PIRQ_N; k++) begin
            if (apic_mode_i) begin
                out_d.apic[APIC_BASE+k] = pirq_i[k];
            end else if (!route_i[k][DIS_BIT] && pirq_i[k]) begin
                out_d.pic[route_i[k][IRQ_W-1:0]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pic_irq_o  = out_q.pic;
    assign apic_irq_o = out_q.apic;

    // R6
    apic_quiet_in_pic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(apic_mode_i) |-> (apic_irq_o == '0));
    // R5
    pic_quiet_in_apic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(apic_mode_i) |-> (pic_irq_o == '0));
    // R5
    apic_low_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apic_irq_o[APIC_BASE-1:0] == '0);
    // R7
    idle_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pirq_i == '0) |-> (pic_irq_o == '0 && apic_irq_o == '0));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pirq_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_FIXED = 25,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS*4-1:0]     intx_i,
    input  logic                       cfg_we_i,
    input  logic [ADDR_W-1:0]          cfg_addr_i,
    input  logic [DATA_W-1:0]          cfg_wdata_i,
    output logic [DATA_W-1:0]          cfg_rdata_o,
    output logic [15:0]                pic_irq_o,
    output logic [23:0]                apic_irq_o
);
    localparam int NPROG = NUM_SLOTS - NUM_FIXED;

    logic                           apic_mode;
    logic [PIRQ_N-1:0][ROUTE_W-1:0] route;
    logic [NPROG-1:0][MAP_W-1:0]    map;
    logic [PIRQ_N-1:0]              pirq;

    pirq_cfg_regs #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_FIXED(NUM_FIXED), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .apic_mode_o(apic_mode),
        .route_o(route), .map_o(map)
    );

    pirq_swizzle #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_FIXED(NUM_FIXED)
    ) u_swz (
        .clk(clk), .rst_n(rst_n), .intx_i(intx_i), .map_i(map), .pirq_o(pirq)
    );

    pirq_deliver u_dlv (
        .clk(clk), .rst_n(rst_n), .apic_mode_i(apic_mode), .route_i(route),
        .pirq_i(pirq), .pic_irq_o(pic_irq_o), .apic_irq_o(apic_irq_o)
    );
endmodule

// File: tb/tb_pci_irq_router.sv
`timescale 1ns/1ps
module tb_pci_irq_router;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] intx = '0;
    logic         we = 1'b0;
    logic [4:0]   addr = '0;
    logic [15:0]  wdata = '0;
    logic [15:0]  rdata;
    logic [15:0]  pic;
    logic [23:0]  apic;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic        sh_mode;
    logic [7:0]  sh_route [8];
    logic [15:0] sh_map [7];

    logic [39:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    pci_irq_router dut (
        .clk(clk), .rst_n(rst_n), .intx_i(intx), .cfg_we_i(we), .cfg_addr_i(addr),
        .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .pic_irq_o(pic), .apic_irq_o(apic)
    );

    function automatic logic [39:0] model(logic [127:0] v);
        logic [7:0]  ln;
        logic [15:0] p;
        logic [23:0] a;
        ln = '0; p = '0; a = '0;
        for (int s = 0; s < 32; s++) begin
            for (int q = 0; q < 4; q++) begin
                if (v[s*4+q]) begin
                    if (s < 25) ln[4 + ((s + q) % 4)] = 1'b1;
                    else begin
                        logic [3:0] f;
                        f = sh_map[s-25][q*4 +: 4];
                        if (!f[3]) ln[f[2:0]] = 1'b1;
                    end
                end
            end
        end
        for (int k = 0; k < 8; k++) begin
            if (sh_mode) a[16+k] = ln[k];
            else if (!sh_route[k][7] && ln[k]) p[sh_route[k][3:0]] = 1'b1;
        end
        return {p, a};
    endfunction

    function automatic logic [15:0] rd_model(int a);
        if (a == 0) return {15'd0, sh_mode};
        if (a >= 8 && a < 16) return {8'd0, sh_route[a-8]};
        if (a >= 25 && a < 32) return sh_map[a-25];
        return 16'd0;
    endfunction

    task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [39:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {pic, apic}, e);
            end
        end
    end

    task automatic apply(logic [127:0] v, string tag);
        @(negedge clk);
        intx = v;
        exp_q.push_back(model(v));
        tag_q.push_back(tag);
    endtask

    task automatic wr(int a, logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = 5'(a); wdata = d;
        if (a == 0) sh_mode = d[0];
        else if (a >= 8 && a < 16) sh_route[a-8] = {d[7], 3'b000, d[3:0]};
        else if (a >= 25 && a < 32) sh_map[a-25] = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        @(negedge clk);
        addr = 5'(a);
        #1;
        check(tag, {24'd0, rdata}, {24'd0, rd_model(a)});
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        sh_mode = 1'b1;
        for (int k = 0; k < 8; k++) sh_route[k] = 8'h80;
        for (int k = 0; k < 7; k++) sh_map[k] = 16'h8888;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs", {pic, apic}, 40'd0);
        rd(0, "R1 mode");
        rd(8, "R1 route A");
        rd(15, "R1 route H");
        rd(25, "R1 map slot25");
        rd(31, "R1 map slot31");

        // R2 R3 R5 single-pin sweep in APIC mode, programmable slots disabled
        for (int i = 0; i < 128; i++) begin
            logic [127:0] v;
            v = '0; v[i] = 1'b1;
            apply(v, (i < 100) ? "R2 fixed pin sweep" : "R3 disabled slot sweep");
        end
        drain();

        // R3 program slots 25 and 31, read back (R8)
        wr(25, 16'h0123);
        wr(31, 16'h8F47);
        wr(28, 16'h6D52);
        rd(25, "R8 map25 readback");
        rd(31, "R8 map31 readback");
        for (int s = 25; s < 32; s++) begin
            for (int q = 0; q < 4; q++) begin
                logic [127:0] v;
                v = '0; v[s*4+q] = 1'b1;
                apply(v, "R3 programmed field");
            end
        end
        drain();

        // R4 OR merging on line E
        begin
            logic [127:0] v;
            v = '0; v[0] = 1'b1; v[16] = 1'b1; v[13] = 1'b1;
            apply(v, "R4 three into E");
            v[16] = 1'b0;
            apply(v, "R4 one dropped");
            v[0] = 1'b0;
            apply(v, "R4 last holds E");
            apply('1, "R4 all high");
            apply('0, "R4 all low");
        end
        drain();

        // R7 latency: outputs change only at the next edge
        begin
            logic [127:0] v;
            v = '0; v[4] = 1'b1;
            apply(v, "R7 setup");
            drain();
            @(negedge clk);
            intx = '0; intx[101] = 1'b1;
            #1;
            check("R7 no early change", {pic, apic}, model(v));
            @(posedge clk); #1;
            check("R7 after edge", {pic, apic}, model(intx));
        end

        // R8 unmapped writes ignored
        wr(20, 16'hFFFF);
        wr(5, 16'hFFFF);
        wr(18, 16'h0000);
        rd(20, "R8 unmapped reads 0");
        rd(5, "R8 unmapped reads 0");
        rd(0, "R8 mode unchanged");
        begin
            logic [127:0] v;
            v = '0; v[72] = 1'b1; v[80] = 1'b1;
            apply(v, "R8 outputs unchanged after unmapped write");
        end
        drain();

        // R6 PIC mode
        wr(0, 16'hFFFE);
        wr(8 + 4, 16'h007B);   // E -> 11, junk bits dropped
        wr(8 + 5, 16'h000B);   // F -> 11
        wr(8 + 0, 16'h0005);   // A -> 5
        wr(8 + 6, 16'h008A);   // G disabled
        wr(8 + 7, 16'h000A);   // H -> 10
        rd(0, "R8 mode bit only");
        rd(12, "R8 route keeps bits 7 and 3:0");
        rd(14, "R8 route disable readback");
        begin
            logic [127:0] v;
            v = '0; v[0] = 1'b1;
            apply(v, "R6 E to 11");
            v = '0; v[1] = 1'b1;
            apply(v, "R6 F to 11");
            v = '0; v[0] = 1'b1; v[1] = 1'b1;
            apply(v, "R6 E and F share 11");
            v = '0; v[2] = 1'b1;
            apply(v, "R6 G disabled");
            v = '0; v[3] = 1'b1; v[103] = 1'b1;
            apply(v, "R6 H and A");
            apply('1, "R6 all high");
        end
        drain();

        // R5 back to APIC mode
        wr(0, 16'h0001);
        apply('1, "R5 APIC all high");
        begin
            logic [127:0] v;
            v = '0; v[100] = 1'b1; v[6] = 1'b1;
            apply(v, "R5 APIC mixed");
        end
        drain();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule